// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Selector

This block takes in 32 raw interrupt status lines and holds a 32-bit mask that software can program. A source is pending only when both its status bit and its mask bit are 1. The CPU handler raises a select strobe to ask which source to service. The block then names one pending source, chosen in round-robin order. No source has a fixed advantage over another.

A rotating start pointer is stored between selections. The search begins at the pointer and moves upward through the indices, wrapping from 31 back to 0. It stops at the first pending source it finds. After a grant, the pointer moves to the index just past the granted one, so that source goes to the back of the line.

The mask port offers four operations:
- hold the mask unchanged,
- load a whole word,
- set one bit,
- clear one bit.

Because of the single-bit operations, software can enable or disable one source without disturbing any of the others. An aggregate line reports to the CPU whenever any source is pending.

Top module: `rr_irq_selector`

## Requirements
- R1: A source counts as pending only when its status bit and its mask bit are both 1. With a zero mask, no status pattern produces a selection or a CPU interrupt.
- R2: `sel_valid` is 1 exactly when `sel_req` is 1 and at least one source is pending. Whenever `sel_valid` is 1, `sel_idx` names a pending source.
- R3: A request made while nothing is pending returns `sel_valid` = 0 and leaves the pointer unchanged. The next successful selection is therefore the one that would have happened without that request.
- R4: The chosen index is the first pending source found by searching upward from the pointer, wrapping from 31 to 0.
- R5: On the clock edge that follows a valid selection of index k, the pointer becomes (k+1) mod 32. A grant of 31 wraps the pointer to 0.
- R6: `mask_op` encoding:
  - 2'b00 holds the mask.
  - 2'b01 loads `mask_wdata`.
  - 2'b10 sets only bit `mask_idx`.
  - 2'b11 clears only bit `mask_idx`.
  - For the set and clear operations, all other mask bits are kept.
- R7: `cpu_irq` is the OR of all pending bits. It does not depend on `sel_req`.
- R8: Reset clears the mask to all zeros and sets the pointer to 0. With all sources pending and an all-ones mask, the first selection after reset is index 0.
- R9: A mask operation takes effect on the next clock edge. `mask_rdata` always shows the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_status | input | 32 | Raw status bit for each source |
| mask_op | input | 2 | Mask operation: hold, load, set bit, clear bit |
| mask_idx | input | 5 | Bit to set or clear |
| mask_wdata | input | 32 | Word used by the load operation |
| mask_rdata | output | 32 | Current mask value |
| sel_req | input | 1 | Select strobe |
| sel_valid | output | 1 | A pending source was chosen |
| sel_idx | output | 5 | Index of the chosen source |
| cpu_irq | output | 1 | Aggregate interrupt line |

## Verification
Several stimulus patterns are used, and each one separates a different behaviour:
- With every source pending, successive grants must march 0, 1, 2 and onward, which sets a fair rotation apart from a fixed lowest-index priority.
- A sparse pattern with only bits 31 and 0 set shows that the search wraps around correctly.
- Requests made while nothing is pending show that the pointer is left alone when there is nothing to grant.
- Single-bit set and clear operations made over a dense mask would reveal any disturbance of the neighbouring bits.
- Constrained random status, mask and strobe traffic is compared cycle by cycle against a bench model of the pointer and the mask.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    typedef enum logic [1:0] {
        MASK_HOLD = 2'b00,
        MASK_LOAD = 2'b01,
        MASK_SET  = 2'b10,
        MASK_CLR  = 2'b11
    } mask_op_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_sel_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op,
    input  logic [IW-1:0] idx,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  mask_q
);
    logic [N-1:0] bit_sel;
    logic [N-1:0] mask_d;

    assign bit_sel = N'(1) << idx;

    always_comb begin
        mask_d = mask_q;
        unique case (mask_op_e'(op))
            MASK_HOLD: mask_d = mask_q;
            MASK_LOAD: mask_d = wdata;
            MASK_SET:  mask_d = mask_q | bit_sel;
            MASK_CLR:  mask_d = mask_q & ~bit_sel;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pending,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    int pos;

    // Walk offsets from the far end back toward the start so the
    // smallest offset from the pointer wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = 0;
        for (int off = N - 1; off >= 0; off--) begin
            pos = (int'(start) + off) % N;
            if (pending[pos]) begin
                found = 1'b1;
                idx   = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/rr_ptr.sv
module rr_ptr #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [IW-1:0] grant,
    output logic [IW-1:0] ptr_q
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] after_grant;
    assign after_grant = (grant == LAST) ? '0 : grant + IW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ptr_q <= '0;
        else if (adv) ptr_q <= after_grant;
    end
endmodule

// File: rtl/rr_irq_selector.sv
module rr_irq_selector #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_status,
    input  logic [1:0]    mask_op,
    input  logic [IW-1:0] mask_idx,
    input  logic [N-1:0]  mask_wdata,
    output logic [N-1:0]  mask_rdata,
    input  logic          sel_req,
    output logic          sel_valid,
    output logic [IW-1:0] sel_idx,
    output logic          cpu_irq
);
    logic [N-1:0]  mask_q;
    logic [N-1:0]  pending;
    logic [IW-1:0] ptr_q;
    logic          any_found;
    logic [IW-1:0] pick_idx;

    irq_mask_reg #(.N(N), .IW(IW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (mask_op),
        .idx    (mask_idx),
        .wdata  (mask_wdata),
        .mask_q (mask_q)
    );

    assign pending = irq_status & mask_q;

    rr_pick #(.N(N), .IW(IW)) u_pick (
        .pending (pending),
        .start   (ptr_q),
        .found   (any_found),
        .idx     (pick_idx)
    );

    rr_ptr #(.N(N), .IW(IW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (sel_valid),
        .grant (pick_idx),
        .ptr_q (ptr_q)
    );

    assign sel_valid  = sel_req & any_found;
    assign sel_idx    = pick_idx;
    assign cpu_irq    = |pending;
    assign mask_rdata = mask_q;
endmodule

// File: rtl/irq_sel_checker.sv
module irq_sel_checker #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_status,
    input logic [1:0]    mask_op,
    input logic [IW-1:0] mask_idx,
    input logic [N-1:0]  mask_rdata,
    input logic          sel_req,
    input logic          sel_valid,
    input logic [IW-1:0] sel_idx,
    input logic          cpu_irq,
    input logic [IW-1:0] ptr_q
);
    p_valid_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (irq_status[sel_idx] && mask_rdata[sel_idx]));

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> $stable(ptr_q));

    p_ptr_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> (ptr_q == IW'((int'($past(sel_idx)) + 1) % N)));

    p_set_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_op == 2'b10) |=>
            (mask_rdata == ($past(mask_rdata) | (N'(1) << $past(mask_idx)))));

    p_clr_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_op == 2'b11) |=>
            (mask_rdata == ($past(mask_rdata) & ~(N'(1) << $past(mask_idx)))));

    p_irq_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && cpu_irq) |-> sel_valid);
endmodule

bind rr_irq_selector irq_sel_checker #(.N(N), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_status (irq_status),
    .mask_op    (mask_op),
    .mask_idx   (mask_idx),
    .mask_rdata (mask_rdata),
    .sel_req    (sel_req),
    .sel_valid  (sel_valid),
    .sel_idx    (sel_idx),
    .cpu_irq    (cpu_irq),
    .ptr_q      (ptr_q)
);

// File: tb/rr_irq_selector_bench.sv
`timescale 1ns/1ps
module rr_irq_selector_bench;
    localparam int N  = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_status = '0;
    logic [1:0]    mask_op = 2'b00;
    logic [IW-1:0] mask_idx = '0;
    logic [N-1:0]  mask_wdata = '0;
    logic [N-1:0]  mask_rdata;
    logic          sel_req = 1'b0;
    logic          sel_valid;
    logic [IW-1:0] sel_idx;
    logic          cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [N-1:0]  m_mask = '0;
    int            m_ptr  = 0;

    always #2.5 clk = ~clk;

    rr_irq_selector u_rr_irq_selector (
        .clk(clk), .rst_n(rst_n), .irq_status(irq_status),
        .mask_op(mask_op), .mask_idx(mask_idx), .mask_wdata(mask_wdata),
        .mask_rdata(mask_rdata), .sel_req(sel_req), .sel_valid(sel_valid),
        .sel_idx(sel_idx), .cpu_irq(cpu_irq)
    );

    function automatic int exp_pick(input logic [N-1:0] pend, input int start);
        for (int off = 0; off < N; off++) begin
            if (pend[(start + off) % N]) return (start + off) % N;
        end
        return -1;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] st, input bit req, input logic [1:0] op,
                        input logic [IW-1:0] idx, input logic [N-1:0] wd, input string tag);
        logic [N-1:0] pend;
        int           p;
        @(negedge clk);
        irq_status = st; sel_req = req; mask_op = op; mask_idx = idx; mask_wdata = wd;
        #1;
        pend = st & m_mask;
        p    = exp_pick(pend, m_ptr);
        chk(32'(cpu_irq), 32'(|pend), "R7");
        chk(32'(sel_valid), 32'(req && (p >= 0)), "R2");
        if (req && p >= 0) chk(32'(sel_idx), 32'(p), tag);
        chk(mask_rdata, m_mask, "R9");
        @(posedge clk);
        if (req && p >= 0) m_ptr = (p + 1) % N;
        case (op)
            2'b01: m_mask = wd;
            2'b10: m_mask = m_mask | (N'(1) << idx);
            2'b11: m_mask = m_mask & ~(N'(1) << idx);
            default: ;
        endcase
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state at the ports
        chk(mask_rdata, '0, "R8");
        irq_status = '1; sel_req = 1'b1; #1;
        chk(32'(cpu_irq), 32'(0), "R1");
        chk(32'(sel_valid), 32'(0), "R1");
        @(negedge clk); rst_n = 1'b1;

        // R1: zero mask hides everything
        step('1, 1'b1, 2'b00, '0, '0, "R1");
        // load all ones; then fair march from 0 (R8, R4)
        step('0, 1'b0, 2'b01, '0, '1, "R9");
        step('1, 1'b1, 2'b00, '0, '0, "R8");
        for (int k = 0; k < 40; k++) step('1, 1'b1, 2'b00, '0, '0, "R4");
        // wrap: only 31 and 0 pending (R5)
        for (int k = 0; k < 6; k++) step(32'h8000_0001, 1'b1, 2'b00, '0, '0, "R5");
        // R3: move pointer to 6, then empty requests, then full
        step(32'h0000_0020, 1'b1, 2'b00, '0, '0, "R4");
        for (int k = 0; k < 4; k++) step('0, 1'b1, 2'b00, '0, '0, "R3");
        step('1, 1'b1, 2'b00, '0, '0, "R3");
        // R6: set/clear single bits in a dense and a sparse mask
        step('0, 1'b0, 2'b11, 5'd7, '0, "R6");
        step('0, 1'b0, 2'b11, 5'd31, '0, "R6");
        step('0, 1'b0, 2'b01, '0, 32'h0000_0000, "R6");
        step('0, 1'b0, 2'b10, 5'd3, '0, "R6");
        step('0, 1'b0, 2'b10, 5'd30, '0, "R6");
        step('0, 1'b0, 2'b00, '0, '0, "R6");
        step('1, 1'b1, 2'b00, '0, '0, "R4");
        step('1, 1'b1, 2'b00, '0, '0, "R4");

        // constrained random traffic
        for (int k = 0; k < 2000; k++) begin
            logic [N-1:0]  st;
            logic [1:0]    op;
            st = $urandom();
            if ($urandom_range(3) == 0) st = st & $urandom();
            op = ($urandom_range(4) == 0) ? 2'($urandom_range(3)) : 2'b00;
            step(st, 1'($urandom_range(1)), op, 5'($urandom_range(31)), $urandom(), "R4");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule